// File: doc/BRIEF.md
# Triple Cascadable Interval Timer with Pulse-Width Capture

This block holds three 16-bit counters clocked from one system clock. Two of them are pin timers. Each pin timer has one input and one output. It can count a base tick, count rising edges on its input, or count the terminal-count pulses of the third timer. In its compare modes it drives either a single-shot or a repeating waveform on its output. Its two compare limits set the high and low phases independently. In capture mode it measures how long its input stays high and how long it stays low.

The third timer, the base timer, has no pins. It always advances on the base tick, which is the system clock divided by `TICK_DIV`. Its terminal count can serve as a shared prescaler for the pin timers. The same terminal count can also raise a one-cycle interrupt pulse, a one-cycle DMA request pulse, or both.

Software reaches all registers through a plain write strobe and a combinational read port. The write port has an address and data. The read port has its own address.

Top module: `tri_timer`

## Requirements
- R1: Address map. Pin timer i (i = 0 or 1) sits at base 8*i, with count at +0, limit A at +1, limit B at +2, control at +3, high capture at +4 and low capture at +5. The base timer's count is at 16, its limit at 17 and its control at 19. Limits store and read back the full 16-bit written value. Writes to a count address are ignored.
- R2: The base timer's control uses bit0 enable, bit1 continuous, bit2 interrupt enable and bit3 DMA enable. While enabled it advances by one on each base tick, which occurs once every `TICK_DIV` clocks. On a tick where the count equals its limit, the count returns to 0 (terminal count), and when continuous is 0 the enable bit clears.
- R3: A pin timer's control uses bit0 enable, bit1 continuous, bit2 alternate, bit3 external, bit4 prescaled and bit5 capture. Read-only bit15 is the capture-valid flag. With external and prescaled both 0, the timer counts base ticks.
- R4: With external set (and capture clear), the pin timer counts rising edges of its input. The input passes two synchronizer flops, so a rise present before clock edge k advances the count at edge k+2.
- R5: With prescaled set (and external clear), the pin timer advances once per base-timer terminal count.
- R6: The cycle after a base-timer terminal count, `irq` pulses for one cycle if bit2 is set, and `dma_req` pulses for one cycle if bit3 is set.
- R7: A count event that finds the count equal to the active limit returns the count to 0 and inverts the timer's output, which is 0 after reset. In alternate mode the active limit swaps between A and B at each such match; otherwise limit A is always active.
- R8: With continuous at 0, the enable bit clears at the first match in single-limit mode, or at the match on limit B in alternate mode.
- R9: In capture mode a synchronized rising input edge copies the count into the low capture, and a falling edge copies it into the high capture. Either edge restarts the count at 0 and sets the valid flag. Between edges the count advances on the selected base or prescaled source.
- R10: Reset clears all registers and outputs. A control write clears that timer's count, its active limit (back to A) and its valid flag, and it takes precedence over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| tmr_in | input | 2 | Pin timer inputs (asynchronous) |
| tmr_out | output | 2 | Pin timer waveform outputs |
| irq | output | 1 | Base-timer terminal-count interrupt pulse |
| dma_req | output | 1 | Base-timer terminal-count DMA request pulse |

## Verification
The bench builds the block with its defaults: `CNT_W` = 16, `TICK_DIV` = 4, `SYNC_STAGES` = 2 and capture enabled. It programs limits of 0 to 3 so that matches, phase swaps, single-shot stops and prescaled cascades all happen within a few hundred cycles. Input pulses of a few dozen clocks keep the captured widths small. Control writes are repeated close together so that some land on the same cycle as a count event.

// File: rtl/tt_pkg.sv
package tt_pkg;
   localparam int ADDR_W      = 5;
   localparam int PIN_STRIDE  = 8;
   localparam int BASE_ADDR   = 16;
   localparam int OFS_CNT     = 0;
   localparam int OFS_LIMA    = 1;
   localparam int OFS_LIMB    = 2;
   localparam int OFS_CTL     = 3;
   localparam int OFS_HICAP   = 4;
   localparam int OFS_LOCAP   = 5;

   // bit0 is the enable bit
   typedef struct packed {
      logic capture;
      logic prescaled;
      logic external;
      logic alternate;
      logic continuous;
      logic enable;
   } pin_ctl_t;

   typedef struct packed {
      logic dma_on;
      logic irq_on;
      logic continuous;
      logic enable;
   } base_ctl_t;
endpackage

// File: rtl/tt_tick_div.sv
module tt_tick_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

   logic [DW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      div_q <= '0;
      else if (div_q == DW'(DIV - 1))  div_q <= '0;
      else                             div_q <= div_q + 1'b1;
   end

   assign tick_o = (div_q == DW'(DIV - 1));

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/tt_in_sync.sv
module tt_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] ff_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= pin_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= {ff_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= ff_q[STAGES-1];
   end

   assign rise_o =  ff_q[STAGES-1] & ~prev_q;
   assign fall_o = ~ff_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/tt_base_timer.sv
module tt_base_timer
   import tt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         wr_lim_i,
   input  logic         wr_ctl_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] lim_o,
   output base_ctl_t    ctl_o,
   output logic         tc_o,
   output logic         irq_o,
   output logic         dma_o
);
   logic [W-1:0] cnt_q, lim_q;
   base_ctl_t    ctl_q;
   logic         irq_q, dma_q;

   assign tc_o = tick_i & ctl_q.enable & (cnt_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ctl_q <= '0;
      end else if (wr_ctl_i) begin
         ctl_q <= base_ctl_t'(wr_data_i[3:0]);
         cnt_q <= '0;
      end else if (tick_i && ctl_q.enable) begin
         if (cnt_q == lim_q) begin
            cnt_q <= '0;
            if (!ctl_q.continuous) ctl_q.enable <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
         irq_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         if (wr_lim_i) lim_q <= wr_data_i;
         irq_q <= tc_o & ctl_q.irq_on;
         dma_q <= tc_o & ctl_q.dma_on;
      end
   end

   assign cnt_o = cnt_q;
   assign lim_o = lim_q;
   assign ctl_o = ctl_q;
   assign irq_o = irq_q;
   assign dma_o = dma_q;

   // R2
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tick_i) && !$past(wr_ctl_i)) |-> $stable(cnt_q));
endmodule

// File: rtl/tt_pin_timer.sv
module tt_pin_timer
   import tt_pkg::*;
#(
   parameter int W       = 16,
   parameter bit CAPTURE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         pre_i,
   input  logic         rise_i,
   input  logic         fall_i,
   input  logic         wr_lima_i,
   input  logic         wr_limb_i,
   input  logic         wr_ctl_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] lima_o,
   output logic [W-1:0] limb_o,
   output pin_ctl_t     ctl_o,
   output logic         valid_o,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o,
   output logic         out_o
);
   logic [W-1:0] cnt_q, lima_q, limb_q;
   pin_ctl_t     ctl_q;
   logic         sel_q, out_q, valid_q;
   logic         cap_on, src_ev, ev, hit, cap_rise, cap_fall, ext_mode;
   logic [W-1:0] active_lim;

   assign cap_on     = ctl_q.capture & CAPTURE;
   assign src_ev     = ctl_q.prescaled ? pre_i : tick_i;
   assign ev         = ctl_q.enable & ((ctl_q.external & ~cap_on) ? rise_i : src_ev);
   assign active_lim = sel_q ? limb_q : lima_q;
   assign hit        = ev & ~cap_on & (cnt_q == active_lim);
   assign cap_rise   = cap_on & ctl_q.enable & rise_i;
   assign cap_fall   = cap_on & ctl_q.enable & fall_i & ~rise_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ctl_q   <= '0;
         sel_q   <= 1'b0;
         out_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (wr_ctl_i) begin
         ctl_q   <= pin_ctl_t'(wr_data_i[5:0]);
         cnt_q   <= '0;
         sel_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (cap_rise || cap_fall) begin
         cnt_q   <= '0;
         valid_q <= 1'b1;
      end else if (hit) begin
         cnt_q <= '0;
         out_q <= ~out_q;
         if (ctl_q.alternate) sel_q <= ~sel_q;
         if (!ctl_q.continuous && (!ctl_q.alternate || sel_q)) ctl_q.enable <= 1'b0;
      end else if (ev) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lima_q <= '0;
         limb_q <= '0;
      end else begin
         if (wr_lima_i) lima_q <= wr_data_i;
         if (wr_limb_i) limb_q <= wr_data_i;
      end
   end

   generate
      if (CAPTURE) begin : g_cap
         logic [W-1:0] hi_q, lo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= '0;
               lo_q <= '0;
            end else if (!wr_ctl_i) begin
               if (cap_rise) lo_q <= cnt_q;
               if (cap_fall) hi_q <= cnt_q;
            end
         end
         assign hi_o = hi_q;
         assign lo_o = lo_q;
      end else begin : g_nocap
         assign hi_o = '0;
         assign lo_o = '0;
      end
   endgenerate

   assign cnt_o   = cnt_q;
   assign lima_o  = lima_q;
   assign limb_o  = limb_q;
   assign ctl_o   = ctl_q;
   assign valid_o = valid_q;
   assign out_o   = out_q;

   assign ext_mode = ctl_q.enable & ctl_q.external & ~cap_on & ~wr_ctl_i;

   // R7
   out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |-> (cnt_q == '0));
   // R9
   cap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> (cnt_q == '0));
   // R4
   ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ext_mode) && !$stable(cnt_q)) |-> $past(rise_i));
endmodule

// File: rtl/tri_timer.sv
module tri_timer
   import tt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int TICK_DIV    = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit CAPTURE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [4:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [1:0]        tmr_in,
   output logic [1:0]        tmr_out,
   output logic              irq,
   output logic              dma_req
);
   localparam int NPIN = 2;
   localparam int PAD  = CNT_W - 7;

   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("tri_timer: CNT_W must be at least 8");
      end
      if (TICK_DIV < 2) begin : g_bad_div
         $error("tri_timer: TICK_DIV must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tri_timer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             tick, t2_tc;
   logic [CNT_W-1:0] t2_cnt, t2_lim;
   base_ctl_t        t2_ctl;
   logic [CNT_W-1:0] pin_rd [NPIN];

   tt_tick_div #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   tt_base_timer #(.W(CNT_W)) u_base (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .wr_lim_i(wr_en && wr_addr == ADDR_W'(BASE_ADDR + OFS_LIMA)),
      .wr_ctl_i(wr_en && wr_addr == ADDR_W'(BASE_ADDR + OFS_CTL)),
      .wr_data_i(wr_data), .cnt_o(t2_cnt), .lim_o(t2_lim), .ctl_o(t2_ctl),
      .tc_o(t2_tc), .irq_o(irq), .dma_o(dma_req));

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         logic             rise, fall, valid;
         logic [CNT_W-1:0] cnt, lima, limb, hi, lo;
         pin_ctl_t         ctl;

         tt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(tmr_in[i]),
            .rise_o(rise), .fall_o(fall));

         tt_pin_timer #(.W(CNT_W), .CAPTURE(CAPTURE)) u_tmr (
            .clk(clk), .rst_n(rst_n), .tick_i(tick), .pre_i(t2_tc),
            .rise_i(rise), .fall_i(fall),
            .wr_lima_i(wr_en && wr_addr == ADDR_W'(i * PIN_STRIDE + OFS_LIMA)),
            .wr_limb_i(wr_en && wr_addr == ADDR_W'(i * PIN_STRIDE + OFS_LIMB)),
            .wr_ctl_i (wr_en && wr_addr == ADDR_W'(i * PIN_STRIDE + OFS_CTL)),
            .wr_data_i(wr_data), .cnt_o(cnt), .lima_o(lima), .limb_o(limb),
            .ctl_o(ctl), .valid_o(valid), .hi_o(hi), .lo_o(lo),
            .out_o(tmr_out[i]));

         always_comb begin
            case (32'(rd_addr[2:0]))
               OFS_CNT:   pin_rd[i] = cnt;
               OFS_LIMA:  pin_rd[i] = lima;
               OFS_LIMB:  pin_rd[i] = limb;
               OFS_CTL:   pin_rd[i] = {valid, {PAD{1'b0}}, ctl};
               OFS_HICAP: pin_rd[i] = hi;
               OFS_LOCAP: pin_rd[i] = lo;
               default:   pin_rd[i] = '0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr[4]) begin
         case (32'(rd_addr[2:0]))
            OFS_CNT:  rd_data = t2_cnt;
            OFS_LIMA: rd_data = t2_lim;
            OFS_CTL:  rd_data = {{(CNT_W-4){1'b0}}, t2_ctl};
            default:  rd_data = '0;
         endcase
      end else begin
         rd_data = pin_rd[rd_addr[3]];
      end
   end

   // R6
   irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (t2_cnt == '0));
   // R6
   dma_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (t2_cnt == '0));
endmodule

// File: tb/tri_timer_tb.sv
`timescale 1ns/1ps
module tri_timer_tb;
   localparam int W   = 16;
   localparam int DIV = 4;
   localparam int MSK = 16'hFFFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [4:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [4:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic [1:0]   tmr_in = '0;
   logic [1:0]   tmr_out;
   logic         irq, dma_req;

   always #4 clk = ~clk;

   tri_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq), .dma_req(dma_req));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string scen_tag = "R10";

   // behavioural reference state
   int m_div, b_cnt, b_lim, b_ctl;
   bit m_irq, m_dma;
   int p_cnt[2], p_a[2], p_b[2], p_ctl[2], p_hi[2], p_lo[2];
   bit p_sel[2], p_out[2], p_val[2];
   bit s0[2], s1[2], sp[2];

   int addr_list[15] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 16, 17, 19};
   int ai = 0;

   function automatic logic [15:0] m_read(input int a);
      int k;
      if (a >= 16) begin
         if (a == 16) return 16'(b_cnt);
         if (a == 17) return 16'(b_lim);
         if (a == 19) return 16'(b_ctl);
         return 16'h0;
      end
      k = a / 8;
      case (a % 8)
         0: return 16'(p_cnt[k]);
         1: return 16'(p_a[k]);
         2: return 16'(p_b[k]);
         3: return 16'((int'(p_val[k]) << 15) | p_ctl[k]);
         4: return 16'(p_hi[k]);
         5: return 16'(p_lo[k]);
         default: return 16'h0;
      endcase
   endfunction

   function automatic string tag_for(input int a);
      if (a == 16 || a == 19) return "R2";
      if (a == 17) return "R1";
      case (a % 8)
         0: return scen_tag;
         1, 2: return "R1";
         3: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_div = 0; b_cnt = 0; b_lim = 0; b_ctl = 0; m_irq = 0; m_dma = 0;
         for (int i = 0; i < 2; i++) begin
            p_cnt[i] = 0; p_a[i] = 0; p_b[i] = 0; p_ctl[i] = 0; p_hi[i] = 0;
            p_lo[i] = 0; p_sel[i] = 0; p_out[i] = 0; p_val[i] = 0;
            s0[i] = 0; s1[i] = 0; sp[i] = 0;
         end
      end else begin
         bit tick, tc;
         tick = (m_div == DIV - 1);
         tc   = tick && b_ctl[0] && (b_cnt == b_lim);
         for (int i = 0; i < 2; i++) begin
            bit en, cont, alt, ext, pre, cap, rise, fall, ev, old_sel;
            int lim;
            en = p_ctl[i][0]; cont = p_ctl[i][1]; alt = p_ctl[i][2];
            ext = p_ctl[i][3]; pre = p_ctl[i][4]; cap = p_ctl[i][5];
            rise = s1[i] && !sp[i];
            fall = !s1[i] && sp[i];
            ev = en && ((ext && !cap) ? rise : (pre ? tc : tick));
            lim = p_sel[i] ? p_b[i] : p_a[i];
            old_sel = p_sel[i];
            if (wr_en && wr_addr == 5'(i * 8 + 3)) begin
               p_ctl[i] = wr_data & 63; p_cnt[i] = 0; p_sel[i] = 0; p_val[i] = 0;
            end else if (cap) begin
               if (en && rise) begin p_lo[i] = p_cnt[i]; p_cnt[i] = 0; p_val[i] = 1; end
               else if (en && fall) begin p_hi[i] = p_cnt[i]; p_cnt[i] = 0; p_val[i] = 1; end
               else if (ev) p_cnt[i] = (p_cnt[i] + 1) & MSK;
            end else if (ev) begin
               if (p_cnt[i] == lim) begin
                  p_cnt[i] = 0;
                  p_out[i] = !p_out[i];
                  if (alt) p_sel[i] = !p_sel[i];
                  if (!cont && (!alt || old_sel)) p_ctl[i] = p_ctl[i] & ~1;
               end else p_cnt[i] = (p_cnt[i] + 1) & MSK;
            end
            if (wr_en && wr_addr == 5'(i * 8 + 1)) p_a[i] = wr_data;
            if (wr_en && wr_addr == 5'(i * 8 + 2)) p_b[i] = wr_data;
            sp[i] = s1[i]; s1[i] = s0[i]; s0[i] = tmr_in[i];
         end
         m_irq = tc && b_ctl[2];
         m_dma = tc && b_ctl[3];
         if (wr_en && wr_addr == 5'd19) begin
            b_ctl = wr_data & 15; b_cnt = 0;
         end else if (tick && b_ctl[0]) begin
            if (b_cnt == b_lim) begin
               b_cnt = 0;
               if (!b_ctl[1]) b_ctl = b_ctl & ~1;
            end else b_cnt = (b_cnt + 1) & MSK;
         end
         if (wr_en && wr_addr == 5'd17) b_lim = wr_data;
         m_div = tick ? 0 : m_div + 1;
      end
   end

   // compare against the reference on every falling edge
   always @(negedge clk) begin
      if (cyc > 0) begin
         chk(tag_for(int'(rd_addr)), rd_data, m_read(int'(rd_addr)));
         chk("R7", {14'h0, tmr_out}, {14'h0, p_out[1], p_out[0]});
         chk("R6", {14'h0, irq, dma_req}, {14'h0, m_irq, m_dma});
         ai = (ai + 1) % 15;
         rd_addr = 5'(addr_list[ai]);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int k, input int hi_n, input int lo_n, input int reps);
      for (int r = 0; r < reps; r++) begin
         @(negedge clk); tmr_in[k] = 1'b1;
         idle(hi_n);
         tmr_in[k] = 1'b0;
         idle(lo_n);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R10 reset state
      idle(5);
      rst_n = 1'b1;
      idle(20);
      // R3 base-tick counting, single limit, continuous
      scen_tag = "R3";
      wr(1, 3); wr(3, 3);
      idle(80);
      // R1 write to count address is ignored
      scen_tag = "R1";
      wr(0, 16'h1234); wr(8, 16'h00AB);
      idle(20);
      // R4 external edges, alternate continuous
      scen_tag = "R4";
      wr(9, 2); wr(10, 1); wr(11, 15);
      pulses(1, 3, 4, 12);
      // R5 prescaled by base timer, with irq and dma
      scen_tag = "R5";
      wr(17, 2); wr(19, 15);
      wr(1, 1); wr(2, 0); wr(3, 23);
      idle(120);
      // R8 single-shot alternate, then single-shot single-limit
      scen_tag = "R8";
      wr(9, 2); wr(10, 3); wr(11, 5);
      idle(80);
      wr(3, 1);
      idle(40);
      // R6 base timer single-shot with irq, then continuous with dma
      scen_tag = "R6";
      wr(19, 5);
      idle(30);
      wr(19, 11);
      idle(30);
      // R9 capture mode on both pin timers
      scen_tag = "R9";
      wr(11, 33); wr(3, 49);
      fork
         pulses(1, 40, 24, 3);
         pulses(0, 50, 30, 2);
      join
      idle(10);
      wr(11, 33);
      idle(10);
      // R10 control writes colliding with count events
      scen_tag = "R10";
      wr(1, 1); wr(3, 3);
      for (int r = 0; r < 10; r++) begin
         wr(3, 3);
         idle(r % 4);
      end
      idle(20);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule